// File: doc/BRIEF.md
# Asynchronous SRAM Interface Controller

This block connects a clocked single-byte request port to an external asynchronous static RAM with 128K locations of 8 bits. A requester offers a read or a write, together with a 17-bit address, through a ready/valid handshake. The controller then produces the active-low chip-select, write-strobe and output-strobe signals, the address, the outgoing byte, and an enable for the tri-state pad buffer. Read data comes back with a one-cycle valid pulse. A write is confirmed with a one-cycle done pulse.

Every transfer passes through four phases: idle, setup, access and recover. In setup the address is already driven and all strobes are inactive. In access the memory is selected, with the write strobe low for a write or the output strobe low for a read. In recover the strobes are inactive again and the memory's drivers are given time to turn off. Each phase lasts a whole number of clocks. That number is computed at elaboration as the ceiling of a minimum time in picoseconds divided by the clock period. The result is at least one cycle.

Reset is asynchronous and active-low, and its release is synchronised inside the block. While reset is active, all strobes are inactive and the controller does not drive the data bus.

Top module: `sram_ctl`

## Requirements
- R1: While reset is asserted, and after its release until a request arrives, mem_ce_n, mem_we_n and mem_oe_n are 1, mem_dq_oe is 0, rsp_valid and wr_done are 0, and req_ready is 1. Asserting reset in the middle of a transfer forces the strobes to 1 and mem_dq_oe to 0 without waiting for a clock edge.
- R2: A request is taken only at a clock edge where req_valid and req_ready are both 1. req_ready is 0 from the cycle after acceptance until the transfer completes. Requests offered in that window are not taken.
- R3: A read keeps mem_ce_n=0, mem_oe_n=0 and mem_we_n=1 for RD_CYC cycles. The byte present on mem_dq_in in the last of those cycles is returned on rsp_rdata. rsp_valid is 1 for exactly one cycle, 1+SETUP_CYC+RD_CYC cycles after the accepting edge.
- R4: A write keeps mem_ce_n=0, mem_we_n=0 and mem_oe_n=1 for WR_CYC cycles, with the request byte on mem_dq_out and mem_dq_oe=1. The byte stays driven in the cycle in which mem_we_n returns to 1. mem_we_n and mem_oe_n are never 0 together.
- R5: wr_done is 1 for exactly one cycle, 1+SETUP_CYC+WR_CYC+REC_CYC cycles after the accepting edge. req_ready is 1 in that same cycle.
- R6: mem_addr equals the accepted address for the whole transfer. It never changes while mem_ce_n is 0.
- R7: mem_dq_oe is 0 whenever mem_oe_n is 0, and for REC_CYC cycles after mem_oe_n rises. The controller and the memory therefore never drive the bus together.
- R8: Each phase length is max(1, ceil(t_min/CLK_PS)). With the defaults (5 ns clock, 10 ns grade) this gives SETUP_CYC=1, RD_CYC=2, WR_CYC=2 and REC_CYC=1. A read then completes in 4 cycles and a write in 5 cycles after acceptance.
- R9: In the setup phase the new address is on mem_addr while mem_ce_n, mem_we_n and mem_oe_n are all still 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Controller idle, request can be taken |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | 17 | Byte address |
| req_wdata | input | 8 | Byte to write |
| rsp_valid | output | 1 | One-cycle read data valid pulse |
| rsp_rdata | output | 8 | Read data |
| wr_done | output | 1 | One-cycle write completion pulse |
| mem_addr | output | 17 | Address to the memory |
| mem_ce_n | output | 1 | Chip select, active low |
| mem_we_n | output | 1 | Write strobe, active low |
| mem_oe_n | output | 1 | Output strobe, active low |
| mem_dq_out | output | 8 | Byte toward the pad buffer |
| mem_dq_oe | output | 1 | Pad buffer drive enable |
| mem_dq_in | input | 8 | Byte from the pad buffer |

## Verification
The bench's memory model puts a garbage byte on the bus until the output strobe has been low for two full cycles. A controller that samples read data one cycle too early therefore returns the wrong byte. The model commits write data only when the write strobe rises. A controller that drops the bus in the same cycle as the strobe rises is flagged for losing data hold.

A write followed at once by a read checks bus turnaround. A controller that keeps driving while the output strobe is low, or in the cycle after it rises, is reported as contention. A request held high during a busy transfer must not be taken. A reset applied in the middle of a read must release the strobes without a clock edge. The extreme addresses 0 and 0x1FFFF catch a truncated address path.

// File: rtl/sram_ctl_pkg.sv
package sram_ctl_pkg;

  typedef enum logic [1:0] {
    ST_IDLE    = 2'd0,
    ST_SETUP   = 2'd1,
    ST_ACCESS  = 2'd2,
    ST_RECOVER = 2'd3
  } st_e;

  // Whole clocks needed to cover t_ps, never fewer than one.
  function automatic int unsigned ceil_cycles(input int unsigned t_ps,
                                              input int unsigned clk_ps);
    int unsigned c;
    c = (t_ps + clk_ps - 1) / clk_ps;
    return (c == 0) ? 1 : c;
  endfunction

  function automatic int unsigned max2(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sram_ctl_rst_sync.sv
module sram_ctl_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_ni
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_ni = sync_q[STAGES-1];
endmodule

// File: rtl/sram_ctl_timer.sv
module sram_ctl_timer #(
  parameter int CNT_W = 2
) (
  input  logic             clk,
  input  logic             rst_ni,
  input  logic             load,
  input  logic [CNT_W-1:0] len,
  output logic             last
);
  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (load)             cnt_d = len - CNT_W'(1);
    else if (cnt_q != '0) cnt_d = cnt_q - CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_d;
  end

  assign last = (cnt_q == '0);

  // R8: a freshly loaded phase never exceeds its programmed length
  p_len_bound_r8: assert property (@(posedge clk) disable iff (!rst_ni)
    load |=> (cnt_q < len || len == '0));
endmodule

// File: rtl/sram_ctl_io.sv
module sram_ctl_io
  import sram_ctl_pkg::*;
#(
  parameter int ADDR_W = 17,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_ni,
  input  logic              accept,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  st_e               state_d,
  input  logic              op_we_d,
  input  logic              capture,
  input  logic              done,
  input  logic [DATA_W-1:0] mem_dq_in,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_ce_n,
  output logic              mem_we_n,
  output logic              mem_oe_n,
  output logic [DATA_W-1:0] mem_dq_out,
  output logic              mem_dq_oe,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              wr_done
);
  logic ce_n_d, we_n_d, oe_n_d, dq_oe_d;

  // Strobes are registered from the next state so they switch cleanly at an edge.
  always_comb begin
    ce_n_d  = (state_d != ST_ACCESS);
    we_n_d  = !((state_d == ST_ACCESS) && op_we_d);
    oe_n_d  = !((state_d == ST_ACCESS) && !op_we_d);
    dq_oe_d = op_we_d && ((state_d == ST_ACCESS) || (state_d == ST_RECOVER));
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      mem_ce_n  <= 1'b1;
      mem_we_n  <= 1'b1;
      mem_oe_n  <= 1'b1;
      mem_dq_oe <= 1'b0;
      rsp_valid <= 1'b0;
      wr_done   <= 1'b0;
    end else begin
      mem_ce_n  <= ce_n_d;
      mem_we_n  <= we_n_d;
      mem_oe_n  <= oe_n_d;
      mem_dq_oe <= dq_oe_d;
      rsp_valid <= capture;
      wr_done   <= done;
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      mem_addr   <= '0;
      mem_dq_out <= '0;
    end else if (accept) begin
      mem_addr   <= req_addr;
      mem_dq_out <= req_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni)      rsp_rdata <= '0;
    else if (capture) rsp_rdata <= mem_dq_in;
  end

  p_we_oe_excl_r4: assert property (@(posedge clk) disable iff (!rst_ni)
    !(!mem_we_n && !mem_oe_n));
  p_data_held_r4: assert property (@(posedge clk) disable iff (!rst_ni)
    $rose(mem_we_n) |-> mem_dq_oe);
  p_no_drive_read_r7: assert property (@(posedge clk) disable iff (!rst_ni)
    mem_dq_oe |-> mem_oe_n);
  p_no_drive_oe_rise_r7: assert property (@(posedge clk) disable iff (!rst_ni)
    $rose(mem_oe_n) |-> !mem_dq_oe);
  p_addr_stable_r6: assert property (@(posedge clk) disable iff (!rst_ni)
    (!mem_ce_n && $past(!mem_ce_n)) |-> $stable(mem_addr));
  p_rsp_pulse_r3: assert property (@(posedge clk) disable iff (!rst_ni)
    rsp_valid |=> !rsp_valid);
  p_done_pulse_r5: assert property (@(posedge clk) disable iff (!rst_ni)
    wr_done |=> !wr_done);
endmodule

// File: rtl/sram_ctl.sv
module sram_ctl
  import sram_ctl_pkg::*;
#(
  parameter int ADDR_W   = 17,
  parameter int DATA_W   = 8,
  parameter int CLK_PS   = 5000,
  parameter int T_AS_PS  = 0,
  parameter int T_WP_PS  = 7000,
  parameter int T_AW_PS  = 8000,
  parameter int T_DW_PS  = 5000,
  parameter int T_CW_PS  = 8000,
  parameter int T_AA_PS  = 10000,
  parameter int T_OE_PS  = 5000,
  parameter int T_OHZ_PS = 5000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_we,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              wr_done,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_ce_n,
  output logic              mem_we_n,
  output logic              mem_oe_n,
  output logic [DATA_W-1:0] mem_dq_out,
  output logic              mem_dq_oe,
  input  logic [DATA_W-1:0] mem_dq_in
);
  localparam int unsigned SETUP_CYC = ceil_cycles(T_AS_PS, CLK_PS);
  localparam int unsigned WR_CYC    = ceil_cycles(max2(max2(T_WP_PS, T_AW_PS),
                                                       max2(T_DW_PS, T_CW_PS)), CLK_PS);
  localparam int unsigned RD_CYC    = ceil_cycles(max2(T_AA_PS, T_OE_PS), CLK_PS);
  localparam int unsigned REC_CYC   = ceil_cycles(T_OHZ_PS, CLK_PS);
  localparam int unsigned MAX_CYC   = max2(max2(SETUP_CYC, WR_CYC), max2(RD_CYC, REC_CYC));
  localparam int          CNT_W     = $clog2(MAX_CYC + 1);

  logic             rst_ni;
  st_e              state_q, state_d;
  logic             op_we_q, op_we_d;
  logic             accept, capture, done;
  logic             tmr_load, tmr_last;
  logic [CNT_W-1:0] tmr_len;

  sram_ctl_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_ni(rst_ni)
  );

  sram_ctl_timer #(.CNT_W(CNT_W)) u_timer (
    .clk(clk), .rst_ni(rst_ni), .load(tmr_load), .len(tmr_len), .last(tmr_last)
  );

  always_comb begin
    state_d  = state_q;
    op_we_d  = op_we_q;
    accept   = 1'b0;
    capture  = 1'b0;
    done     = 1'b0;
    tmr_load = 1'b0;
    tmr_len  = '0;
    case (state_q)
      ST_IDLE: if (req_valid) begin
        accept   = 1'b1;
        op_we_d  = req_we;
        state_d  = ST_SETUP;
        tmr_load = 1'b1;
        tmr_len  = CNT_W'(SETUP_CYC);
      end
      ST_SETUP: if (tmr_last) begin
        state_d  = ST_ACCESS;
        tmr_load = 1'b1;
        tmr_len  = op_we_q ? CNT_W'(WR_CYC) : CNT_W'(RD_CYC);
      end
      ST_ACCESS: if (tmr_last) begin
        state_d  = ST_RECOVER;
        capture  = !op_we_q;
        tmr_load = 1'b1;
        tmr_len  = CNT_W'(REC_CYC);
      end
      ST_RECOVER: if (tmr_last) begin
        state_d = ST_IDLE;
        done    = op_we_q;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      op_we_q <= 1'b0;
    end else begin
      state_q <= state_d;
      op_we_q <= op_we_d;
    end
  end

  assign req_ready = (state_q == ST_IDLE);

  sram_ctl_io #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_io (
    .clk(clk), .rst_ni(rst_ni), .accept(accept),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .state_d(state_d), .op_we_d(op_we_d), .capture(capture), .done(done),
    .mem_dq_in(mem_dq_in), .mem_addr(mem_addr), .mem_ce_n(mem_ce_n),
    .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n), .mem_dq_out(mem_dq_out),
    .mem_dq_oe(mem_dq_oe), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .wr_done(wr_done)
  );

  p_accept_busy_r2: assert property (@(posedge clk) disable iff (!rst_ni)
    (req_valid && req_ready) |=> !req_ready);
  p_setup_quiet_r9: assert property (@(posedge clk) disable iff (!rst_ni)
    (state_q == ST_SETUP) |-> (mem_ce_n && mem_we_n && mem_oe_n));
  p_access_select_r3: assert property (@(posedge clk) disable iff (!rst_ni)
    (state_q == ST_ACCESS) |-> !mem_ce_n);
endmodule

// File: tb/sram_ctl_tb_top.sv
`timescale 1ns/1ps
module sram_ctl_tb_top;
  localparam int S_CYC = 1, R_CYC = 2, W_CYC = 2, C_CYC = 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_we = 1'b0;
  logic [16:0] req_addr = '0;
  logic [7:0]  req_wdata = '0;
  logic req_ready, rsp_valid, wr_done;
  logic [7:0] rsp_rdata, mem_dq_out;
  logic [16:0] mem_addr;
  logic mem_ce_n, mem_we_n, mem_oe_n, mem_dq_oe;
  logic [7:0] mem_dq_in = 8'hEE;

  int errors = 0;
  int checks = 0;

  always #2.5 clk = ~clk;

  sram_ctl dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_we(req_we), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .wr_done(wr_done),
    .mem_addr(mem_addr), .mem_ce_n(mem_ce_n), .mem_we_n(mem_we_n),
    .mem_oe_n(mem_oe_n), .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe),
    .mem_dq_in(mem_dq_in)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // ---------------- memory model ----------------
  logic [7:0] mdl_mem [logic [16:0]];
  int   oe_cnt = 0;
  logic prev_we_low = 1'b0, prev_drv = 1'b0, prev_ce_low = 1'b0;
  logic [16:0] prev_addr = '0;

  function automatic logic [7:0] peek(input logic [16:0] a);
    if (mdl_mem.exists(a)) return mdl_mem[a];
    return a[7:0] ^ 8'h5A;
  endfunction

  always @(negedge clk) begin
    logic drv;
    if (prev_we_low && mem_we_n) begin
      chk(mem_dq_oe, "R4", "data held at write-strobe rise", mem_dq_oe, 1);
      mdl_mem[prev_addr] = mem_dq_out;
    end
    if (!mem_ce_n && prev_ce_low)
      chk(mem_addr == prev_addr, "R6", "address moved while selected", mem_addr, prev_addr);
    drv = !mem_ce_n && !mem_oe_n && mem_we_n;
    if (mem_dq_oe && (drv || prev_drv))
      chk(1'b0, "R7", "bus contention", 1, 0);
    oe_cnt = drv ? oe_cnt + 1 : 0;
    mem_dq_in = (drv && oe_cnt >= 2) ? peek(mem_addr) : 8'hEE;
    prev_we_low = !mem_ce_n && !mem_we_n;
    prev_drv    = drv;
    prev_ce_low = !mem_ce_n;
    prev_addr   = mem_addr;
  end

  // ---------------- one transfer ----------------
  task automatic run_op(input logic we, input logic [16:0] a, input logic [7:0] d,
                        output logic [7:0] rd, output int lat);
    int ce_low;
    @(negedge clk);
    chk(req_ready, "R2", "ready before request", req_ready, 1);
    req_valid = 1'b1; req_we = we; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0;
    lat = 0; rd = '0; ce_low = 0;
    for (int i = 1; i <= 10; i++) begin
      if (i == 1) begin
        chk(mem_ce_n && mem_we_n && mem_oe_n, "R9", "strobes idle in setup", mem_ce_n, 1);
        chk(mem_addr == a, "R9", "address in setup", mem_addr, a);
      end
      if (!mem_ce_n) begin
        ce_low++;
        chk(mem_addr == a, "R6", "address during access", mem_addr, a);
        chk(mem_we_n == !we && mem_oe_n == we, "R3", "strobe pattern", {mem_we_n, mem_oe_n}, {!we, we});
        if (we) chk(mem_dq_oe && mem_dq_out == d, "R4", "write data driven", mem_dq_out, d);
      end
      if (we ? wr_done : rsp_valid) begin
        lat = i; rd = rsp_rdata;
        break;
      end
      chk(!req_ready, "R2", "ready low while busy", req_ready, 0);
      @(negedge clk);
    end
    chk(ce_low == (we ? W_CYC : R_CYC), we ? "R4" : "R3", "select length", ce_low, we ? W_CYC : R_CYC);
    if (we) chk(req_ready, "R5", "ready with done", req_ready, 1);
    @(negedge clk);
    chk(!(we ? wr_done : rsp_valid), we ? "R5" : "R3", "single-cycle pulse", 1, 0);
  endtask

  typedef struct packed {
    logic        we;
    logic [16:0] addr;
    logic [7:0]  data;
  } vec_t;

  localparam vec_t VECS [11] = '{
    '{1'b1, 17'h00000, 8'h3C}, '{1'b1, 17'h1FFFF, 8'hC3},
    '{1'b1, 17'h0AAAA, 8'h55}, '{1'b1, 17'h15555, 8'hAA},
    '{1'b0, 17'h00000, 8'h3C}, '{1'b0, 17'h1FFFF, 8'hC3},
    '{1'b0, 17'h0AAAA, 8'h55}, '{1'b0, 17'h15555, 8'hAA},
    '{1'b0, 17'h00123, 8'h79}, '{1'b1, 17'h00000, 8'h81},
    '{1'b0, 17'h00000, 8'h81}
  };

  initial begin
    repeat (20000) @(posedge clk);
    errors++; checks++;
    $display("FAIL R2 watchdog: actual=hung expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [7:0] rd;
    int lat;
    // R1: reset state
    repeat (3) @(negedge clk);
    chk(mem_ce_n && mem_we_n && mem_oe_n, "R1", "strobes in reset", {mem_ce_n, mem_we_n, mem_oe_n}, 7);
    chk(!mem_dq_oe && !rsp_valid && !wr_done, "R1", "outputs quiet in reset", mem_dq_oe, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(req_ready && mem_ce_n && !mem_dq_oe, "R1", "idle after release", req_ready, 1);

    // table walk: R3 R4 R5 R8
    foreach (VECS[k]) begin
      run_op(VECS[k].we, VECS[k].addr, VECS[k].data, rd, lat);
      if (VECS[k].we)
        chk(lat == 1 + S_CYC + W_CYC + C_CYC, "R8", "write latency", lat, 1 + S_CYC + W_CYC + C_CYC);
      else begin
        chk(lat == 1 + S_CYC + R_CYC, "R8", "read latency", lat, 1 + S_CYC + R_CYC);
        chk(rd == VECS[k].data, "R3", "read data", rd, VECS[k].data);
      end
    end

    // R2/R7: write held during busy then read at once (turnaround)
    @(negedge clk);
    req_valid = 1'b1; req_we = 1'b1; req_addr = 17'h00777; req_wdata = 8'h96;
    @(negedge clk);
    req_addr = 17'h00999; req_wdata = 8'h11;  // offered while busy: must be ignored
    for (int i = 0; i < 10 && !wr_done; i++) @(negedge clk);
    chk(wr_done, "R5", "done for held write", wr_done, 1);
    req_we = 1'b0; req_addr = 17'h00777;
    @(negedge clk);
    req_valid = 1'b0;
    for (int i = 0; i < 10 && !rsp_valid; i++) @(negedge clk);
    chk(rsp_rdata == 8'h96, "R2", "first request kept, busy offer ignored", rsp_rdata, 8'h96);
    @(negedge clk);
    run_op(1'b0, 17'h00999, 8'h00, rd, lat);
    chk(rd == (8'h99 ^ 8'h5A), "R2", "busy offer not written", rd, 8'h99 ^ 8'h5A);

    // R1: reset in the middle of a read
    @(negedge clk);
    req_valid = 1'b1; req_we = 1'b0; req_addr = 17'h0AAAA;
    @(negedge clk);
    req_valid = 1'b0;
    @(negedge clk);
    chk(!mem_oe_n, "R3", "read strobe active before reset", mem_oe_n, 0);
    rst_n = 1'b0;
    #1;
    chk(mem_ce_n && mem_oe_n && mem_we_n && !mem_dq_oe, "R1", "async strobe release",
        {mem_ce_n, mem_oe_n, mem_we_n}, 7);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(req_ready && !rsp_valid, "R1", "idle after mid-op reset", req_ready, 1);
    run_op(1'b0, 17'h0AAAA, 8'h00, rd, lat);
    chk(rd == 8'h55, "R3", "read after reset", rd, 8'h55);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule